// File: doc/BRIEF.md
# Strobe-Framed Synchronous Serial Port

This block is a single-timeslot serial port. An external, active-high strobe marks one slot of `SLOT_BITS` bits (eight by default) in each frame, nominally once every 125 us. Inside that slot the port sends one parallel word, most significant bit first, on its serial output. In the same slot it assembles one word from its serial input. Only bearer data passes through the port. There are no control or signalling channels, and the strobe alone decides which slot is used.

Two clocking cases are supported. With a fast bit clock (512 kHz and up), the shift logic runs directly on the bit clock. Output bits change on its rising edges and input bits are sampled on its falling edges. With a slow bit clock (128 kHz or 256 kHz), the port runs on a 4.096 MHz master clock instead. The bit clock, strobe and serial input pass through a synchronizer. Bit-clock edges are detected on the synchronized copies, and every strobe re-starts the slot timing. Three configuration inputs select the clocking case and the bit rate. Combinations that name no supported rate switch the port off.

The serial output comes with a separate enable that is high only while a slot bit is being driven. The integrator builds the tri-state pad from it.

Top module: `strobe_slot_port`

## Requirements
- R1: While reset is active, and right after it, `ser_oe` is 0, `rx_valid` is 0 and `rx_word` is all zeros.
- R2: In the synchronous mode (`cfg_async`=0 with `cfg_rate` 00, 01 or 10), the first rising edge of `bit_clk` that sees `slot_strobe` high captures `tx_word` and drives its MSB. Each following rising edge drives the next lower bit, with `ser_oe`=1 throughout.
- R3: While `slot_strobe` is high, `ser_in` is sampled on falling edges of `bit_clk`, MSB first. After the eighth sample of a slot, `rx_word` holds the assembled word and `rx_valid` is 1.
- R4: `rx_valid` stays 1 until the first sample of the next slot, which clears it. A slot that ends before its eighth sample leaves `rx_word` unchanged and `rx_valid` at 0.
- R5: A rising bit-clock edge that sees `slot_strobe` low drives `ser_oe` to 0. While `ser_oe` is 0, `ser_out` is 0.
- R6: If the strobe stays high beyond eight bits, `ser_oe` goes to 0 at the ninth rising edge. The extra input bits do not alter `rx_word`.
- R7: In the asynchronous mode (`cfg_async`=1 with `cfg_rate` 00 = 128 kHz or 01 = 256 kHz), the port behaves as in R2 to R6. Each output bit appears within `SYNC_STAGES`+1 master-clock cycles of the bit-clock rising edge.
- R8: The reserved settings (`cfg_async`=0 with `cfg_rate`=11, and `cfg_async`=1 with `cfg_rate`=10 or 11) keep `ser_oe` at 0 and never set `rx_valid`.
- R9: Each new strobe re-starts the slot at the MSB of both directions, whatever happened in the previous slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | 4.096 MHz master clock for the asynchronous mode |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_clk | input | 1 | External serial bit clock |
| slot_strobe | input | 1 | Active-high slot marker |
| ser_in | input | 1 | Serial receive data |
| ser_out | output | 1 | Serial transmit data, 0 when not driven |
| ser_oe | output | 1 | Output enable for the serial pad |
| cfg_async | input | 1 | 1 = slow bit clock with master clock |
| cfg_rate | input | 2 | Bit-rate code (see R2, R7, R8) |
| tx_word | input | SLOT_BITS | Word to send in the next slot |
| rx_word | output | SLOT_BITS | Last complete word received |
| rx_valid | output | 1 | `rx_word` holds the latest full slot |

## Verification
The hardest case to reach is the asynchronous path, where strobe, data and bit-clock edges arrive through the synchronizer. A slot boundary can then fall within a few master-clock cycles of a bit edge. The bench derives every strobe and data change from a fixed count of master-clock cycles after the matching bit-clock edge. This puts each change on the intended side of the synchronized edge while still leaving only the minimum margin the synchronizer needs. Over-long and cut-short strobes are driven in both clocking modes to reach the saturation and abort paths of the slot counters.

// File: rtl/ssp_pkg.sv
package ssp_pkg;

   typedef enum logic [1:0] {
      PORT_OFF   = 2'd0,
      PORT_SYNC  = 2'd1,
      PORT_ASYNC = 2'd2
   } port_mode_e;

   // Rate codes: direct clock 00/01/10 usable, 11 reserved;
   // oversampled clock 00/01 usable, 1x reserved.
   function automatic port_mode_e decode_mode(input logic       async_sel,
                                              input logic [1:0] rate,
                                              input logic       async_ok);
      if (!async_sel)
         return (rate == 2'b11) ? PORT_OFF : PORT_SYNC;
      if (async_ok && !rate[1])
         return PORT_ASYNC;
      return PORT_OFF;
   endfunction

endpackage

// File: rtl/ssp_sync_edge.sv
module ssp_sync_edge #(
   parameter int STAGES = 2,
   parameter int LANES  = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LANES-1:0] async_i,
   output logic [LANES-1:0] sync_o,
   output logic             rise_o,
   output logic             fall_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("ssp_sync_edge: STAGES must be at least 2");
   end
   if (LANES < 1) begin : g_bad_lanes
      $error("ssp_sync_edge: LANES must be at least 1");
   end

   logic [STAGES-1:0][LANES-1:0] stage_q;
   logic                         lane0_d;

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[0] <= '0;
            else        stage_q[0] <= async_i;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[s] <= '0;
            else        stage_q[s] <= stage_q[s-1];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lane0_d <= 1'b0;
      else        lane0_d <= stage_q[STAGES-1][0];
   end

   assign sync_o = stage_q[STAGES-1];
   assign rise_o = stage_q[STAGES-1][0] & ~lane0_d;
   assign fall_o = ~stage_q[STAGES-1][0] & lane0_d;

   AST_EDGE_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
      rise_o |=> !rise_o) else $error("edge detector fired twice");  // R7

endmodule

// File: rtl/ssp_tx_slot.sv
module ssp_tx_slot #(
   parameter int SLOT_BITS = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 evt_i,
   input  logic                 stb_i,
   input  logic                 en_i,
   input  logic [SLOT_BITS-1:0] word_i,
   output logic                 dout_o,
   output logic                 oe_o
);

   localparam int CW = $clog2(SLOT_BITS + 1);

   if (SLOT_BITS < 2) begin : g_bad_width
      $error("ssp_tx_slot: SLOT_BITS must be at least 2");
   end

   logic [SLOT_BITS-1:0] sh_q;
   logic [CW-1:0]        cnt_q;
   logic                 stb_q;
   logic                 bit_q;
   logic                 oe_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q  <= '0;
         cnt_q <= '0;
         stb_q <= 1'b0;
         bit_q <= 1'b0;
         oe_q  <= 1'b0;
      end else if (evt_i) begin
         stb_q <= stb_i;
         if (!stb_i) begin
            oe_q  <= 1'b0;
            cnt_q <= '0;
         end else if (!stb_q) begin
            bit_q <= word_i[SLOT_BITS-1];
            sh_q  <= {word_i[SLOT_BITS-2:0], 1'b0};
            oe_q  <= en_i;
            cnt_q <= CW'(1);
         end else if (cnt_q != CW'(SLOT_BITS)) begin
            bit_q <= sh_q[SLOT_BITS-1];
            sh_q  <= {sh_q[SLOT_BITS-2:0], 1'b0};
            cnt_q <= cnt_q + 1'b1;
         end else begin
            oe_q  <= 1'b0;
         end
      end
   end

   assign oe_o   = oe_q;
   assign dout_o = bit_q & oe_q;

   AST_TX_IDLE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_i && !stb_i) |=> !oe_o) else $error("driving outside slot");  // R5
   AST_TX_START_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(oe_o) |-> $past(evt_i && stb_i && en_i)) else $error("enable without slot start");  // R2

endmodule

// File: rtl/ssp_rx_slot.sv
module ssp_rx_slot #(
   parameter int SLOT_BITS = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 evt_i,
   input  logic                 stb_i,
   input  logic                 en_i,
   input  logic                 din_i,
   output logic [SLOT_BITS-1:0] word_o,
   output logic                 valid_o
);

   localparam int CW = $clog2(SLOT_BITS + 1);

   if (SLOT_BITS < 2) begin : g_bad_width
      $error("ssp_rx_slot: SLOT_BITS must be at least 2");
   end

   logic [SLOT_BITS-1:0] sh_q;
   logic [SLOT_BITS-1:0] word_q;
   logic [CW-1:0]        cnt_q;
   logic                 valid_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q    <= '0;
         word_q  <= '0;
         cnt_q   <= '0;
         valid_q <= 1'b0;
      end else if (evt_i) begin
         if (!stb_i) begin
            cnt_q <= '0;
         end else if (en_i && (cnt_q != CW'(SLOT_BITS))) begin
            sh_q  <= {sh_q[SLOT_BITS-2:0], din_i};
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == '0)
               valid_q <= 1'b0;
            if (cnt_q == CW'(SLOT_BITS - 1)) begin
               word_q  <= {sh_q[SLOT_BITS-2:0], din_i};
               valid_q <= 1'b1;
            end
         end
      end
   end

   assign word_o  = word_q;
   assign valid_o = valid_q;

   AST_RX_VALID_SRC: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(valid_o) |-> $past(evt_i && stb_i && en_i)) else $error("valid without sample");  // R3
   AST_RX_WORD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && $past(valid_o)) |-> $stable(word_o)) else $error("word moved while valid");  // R4

endmodule

// File: rtl/strobe_slot_port.sv
module strobe_slot_port
   import ssp_pkg::*;
#(
   parameter int SLOT_BITS   = 8,
   parameter int SYNC_STAGES = 2,
   parameter bit ASYNC_EN    = 1'b1
) (
   input  logic                 mclk,
   input  logic                 rst_n,
   input  logic                 bit_clk,
   input  logic                 slot_strobe,
   input  logic                 ser_in,
   output logic                 ser_out,
   output logic                 ser_oe,
   input  logic                 cfg_async,
   input  logic [1:0]           cfg_rate,
   input  logic [SLOT_BITS-1:0] tx_word,
   output logic [SLOT_BITS-1:0] rx_word,
   output logic                 rx_valid
);

   if (SLOT_BITS < 2) begin : g_bad_width
      $error("strobe_slot_port: SLOT_BITS must be at least 2");
   end

   port_mode_e mode;
   logic       sync_en;
   logic       async_en;
   logic       bit_clk_n;

   assign mode      = decode_mode(cfg_async, cfg_rate, ASYNC_EN);
   assign sync_en   = (mode == PORT_SYNC);
   assign async_en  = (mode == PORT_ASYNC);
   assign bit_clk_n = ~bit_clk;

   // direct engine: drive on rising edge, sample on falling edge
   logic                 s_dout, s_oe, s_valid;
   logic [SLOT_BITS-1:0] s_word;

   ssp_tx_slot #(.SLOT_BITS(SLOT_BITS)) u_tx_direct (
      .clk    (bit_clk),
      .rst_n  (rst_n),
      .evt_i  (1'b1),
      .stb_i  (slot_strobe),
      .en_i   (sync_en),
      .word_i (tx_word),
      .dout_o (s_dout),
      .oe_o   (s_oe)
   );

   ssp_rx_slot #(.SLOT_BITS(SLOT_BITS)) u_rx_direct (
      .clk     (bit_clk_n),
      .rst_n   (rst_n),
      .evt_i   (1'b1),
      .stb_i   (slot_strobe),
      .en_i    (sync_en),
      .din_i   (ser_in),
      .word_o  (s_word),
      .valid_o (s_valid)
   );

   // oversampled engine on the master clock
   logic                 a_dout, a_oe, a_valid;
   logic [SLOT_BITS-1:0] a_word;

   if (ASYNC_EN) begin : g_async
      logic [2:0] lanes_s;
      logic       bclk_rise, bclk_fall;

      ssp_sync_edge #(.STAGES(SYNC_STAGES), .LANES(3)) u_sync (
         .clk     (mclk),
         .rst_n   (rst_n),
         .async_i ({ser_in, slot_strobe, bit_clk}),
         .sync_o  (lanes_s),
         .rise_o  (bclk_rise),
         .fall_o  (bclk_fall)
      );

      ssp_tx_slot #(.SLOT_BITS(SLOT_BITS)) u_tx_over (
         .clk    (mclk),
         .rst_n  (rst_n),
         .evt_i  (bclk_rise),
         .stb_i  (lanes_s[1]),
         .en_i   (async_en),
         .word_i (tx_word),
         .dout_o (a_dout),
         .oe_o   (a_oe)
      );

      ssp_rx_slot #(.SLOT_BITS(SLOT_BITS)) u_rx_over (
         .clk     (mclk),
         .rst_n   (rst_n),
         .evt_i   (bclk_fall),
         .stb_i   (lanes_s[1]),
         .en_i    (async_en),
         .din_i   (lanes_s[2]),
         .word_o  (a_word),
         .valid_o (a_valid)
      );
   end else begin : g_no_async
      assign a_dout  = 1'b0;
      assign a_oe    = 1'b0;
      assign a_valid = 1'b0;
      assign a_word  = '0;
   end

   always_comb begin
      if (async_en) begin
         ser_out  = a_dout;
         ser_oe   = a_oe;
         rx_word  = a_word;
         rx_valid = a_valid;
      end else begin
         ser_out  = s_dout;
         ser_oe   = s_oe;
         rx_word  = s_word;
         rx_valid = s_valid;
      end
   end

endmodule

// File: tb/strobe_slot_port_tb.sv
module strobe_slot_port_tb;

   localparam int HALF = 16;   // bit clock half period in master clocks

   logic       mclk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bit_clk = 1'b0;
   logic       slot_strobe = 1'b0;
   logic       ser_in = 1'b0;
   logic       ser_out, ser_oe;
   logic       cfg_async = 1'b0;
   logic [1:0] cfg_rate = 2'b00;
   logic [7:0] tx_word = 8'h00;
   logic [7:0] rx_word;
   logic       rx_valid;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2 mclk = ~mclk;

   strobe_slot_port u_dut (
      .mclk        (mclk),
      .rst_n       (rst_n),
      .bit_clk     (bit_clk),
      .slot_strobe (slot_strobe),
      .ser_in      (ser_in),
      .ser_out     (ser_out),
      .ser_oe      (ser_oe),
      .cfg_async   (cfg_async),
      .cfg_rate    (cfg_rate),
      .tx_word     (tx_word),
      .rx_word     (rx_word),
      .rx_valid    (rx_valid)
   );

   task automatic wait_clk(input int n);
      repeat (n) @(posedge mclk);
      #1;
   endtask

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %0h expected %0h at %0t", tag, act, exp, $time);
      end
   endtask

   // One strobe window of nbits bit periods, then one idle rising edge.
   task automatic run_slot(input string tag, input logic [7:0] txb, input logic [7:0] rxb,
                           input int nbits, input bit on, input bit exp_v,
                           input logic [7:0] exp_w);
      tx_word = txb;
      wait_clk(4);
      chk("R5", {15'd0, ser_oe}, 16'd0);
      slot_strobe = 1'b1;
      for (int i = 0; i < nbits; i++) begin
         wait_clk(HALF - 4);
         bit_clk = 1'b1;
         wait_clk(4);
         ser_in = (i < 8) ? rxb[7-i] : ~rxb[i-8];
         wait_clk(HALF - 6);
         if (on && i < 8)
            chk(tag, {14'd0, ser_oe, ser_out}, {14'd0, 1'b1, txb[7-i]});
         else
            chk((i >= 8) ? "R6" : tag, {15'd0, ser_oe}, 16'd0);
         wait_clk(2);
         bit_clk = 1'b0;
      end
      wait_clk(4);
      slot_strobe = 1'b0;
      wait_clk(HALF - 8);
      bit_clk = 1'b1;
      wait_clk(HALF - 2);
      chk("R5", {15'd0, ser_oe}, 16'd0);
      wait_clk(2);
      bit_clk = 1'b0;
      chk("R3/R4 valid", {15'd0, rx_valid}, {15'd0, exp_v});
      chk("R3/R4 word", {8'd0, rx_word}, {8'd0, exp_w});
   endtask

   task automatic t_reset;
      wait_clk(3);
      chk("R1 oe", {15'd0, ser_oe}, 16'd0);
      chk("R1 valid", {15'd0, rx_valid}, 16'd0);
      chk("R1 word", {8'd0, rx_word}, 16'd0);
      rst_n = 1'b1;
      wait_clk(3);
      chk("R1 oe post", {15'd0, ser_oe}, 16'd0);
      chk("R1 valid post", {15'd0, rx_valid}, 16'd0);
   endtask

   task automatic t_reserved;
      cfg_async = 1'b0; cfg_rate = 2'b11;
      run_slot("R8", 8'hFF, 8'hA5, 8, 1'b0, 1'b0, 8'h00);
      cfg_async = 1'b1; cfg_rate = 2'b10;
      run_slot("R8", 8'hFF, 8'h5A, 8, 1'b0, 1'b0, 8'h00);
      cfg_rate = 2'b11;
      run_slot("R8", 8'h81, 8'h7E, 8, 1'b0, 1'b0, 8'h00);
   endtask

   task automatic t_direct;
      cfg_async = 1'b0; cfg_rate = 2'b00;
      run_slot("R2", 8'hA5, 8'h3C, 8, 1'b1, 1'b1, 8'h3C);
      cfg_rate = 2'b10;
      run_slot("R2", 8'h01, 8'h80, 8, 1'b1, 1'b1, 8'h80);
      cfg_rate = 2'b01;
      run_slot("R2", 8'hFF, 8'h00, 8, 1'b1, 1'b1, 8'h00);
      run_slot("R3", 8'h00, 8'hFF, 8, 1'b1, 1'b1, 8'hFF);
   endtask

   task automatic t_direct_long;
      cfg_async = 1'b0; cfg_rate = 2'b00;
      run_slot("R6", 8'hC6, 8'h9B, 11, 1'b1, 1'b1, 8'h9B);
   endtask

   task automatic t_abort_realign;
      cfg_async = 1'b0; cfg_rate = 2'b00;
      run_slot("R4", 8'h12, 8'h5A, 8, 1'b1, 1'b1, 8'h5A);
      run_slot("R4", 8'hE0, 8'hFF, 3, 1'b1, 1'b0, 8'h5A);
      run_slot("R9", 8'h6D, 8'hC3, 8, 1'b1, 1'b1, 8'hC3);
   endtask

   task automatic t_oversampled;
      cfg_async = 1'b1; cfg_rate = 2'b00;
      run_slot("R7", 8'h96, 8'h69, 8, 1'b1, 1'b1, 8'h69);
      cfg_rate = 2'b01;
      run_slot("R7", 8'h0F, 8'hF0, 8, 1'b1, 1'b1, 8'hF0);
      run_slot("R7", 8'h55, 8'hAA, 10, 1'b1, 1'b1, 8'hAA);
      run_slot("R7", 8'h3E, 8'h00, 4, 1'b1, 1'b0, 8'hAA);
      run_slot("R9", 8'hB4, 8'h2D, 8, 1'b1, 1'b1, 8'h2D);
   endtask

   initial begin
      t_reset();
      t_reserved();
      t_direct();
      t_direct_long();
      t_abort_realign();
      t_oversampled();
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge mclk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule